// File: doc/BRIEF.md
# Privileged Status Register Unit

This block keeps a processor's 16-bit status word and its separate user stack pointer, and it executes the small group of instructions that read or change them. An upstream decoder presents one request at a time: an operation class, the low six opcode bits, a 16-bit operand (an immediate word or a value already fetched through an addressing mode), the extra addressing-mode cycle cost, and the value of the address register selected by the opcode. One cycle after a request is accepted, the block reports a done pulse, the cycle cost of the operation and any result word or address-register write.

Bit 13 of the status word is the supervisor flag. Operations that write the full status word, and moves of the user stack pointer, are allowed only while that bit is set. In user mode such a request raises a privilege-violation pulse and changes nothing. Raising the exception is left to other logic. Operations that replace only the condition-code byte, or that read the status word, are allowed in either mode.

Top module: `psw_priv_unit`

## Requirements
- R1: A synchronous active-high reset sets the status word to 0x2700 and the user stack pointer to 0, and clears done, violation, cost, result word and the address-register write enable. `req_ready` is low while reset is held.
- R2: Class 1 (full status write), in supervisor mode, loads the operand into the status word and reports a cost of 12 plus `ea_cost`.
- R3: Classes 3, 4 and 5 (AND, OR and XOR of the status word with the immediate operand), in supervisor mode, combine the operand into the status word with that function and report a cost of 20.
- R4: Classes 1, 3, 4, 5 and 7 while status bit 13 is 0 raise `priv_viol` for one cycle, report cost 0, leave the status word and user stack pointer unchanged, and write no address register.
- R5: Class 6 (condition-code write) keeps status bits 15:8, puts operand bits 7:0 into status bits 7:0, works in either mode, and reports a cost of 12 plus `ea_cost`.
- R6: Class 7 (user stack pointer move) reports a cost of 4. With opcode bit 3 equal to 0, it loads `areg_rdata` into the user stack pointer. With opcode bit 3 equal to 1, it writes the user stack pointer to address register opcode[2:0]. `areg_ridx` always shows opcode[2:0].
- R7: Class 2 (status read) works in either mode and returns the status word as it was before the operation on `res_word`. The cost is 6 when the mode field, opcode[5:3], is 0, and 8 plus `ea_cost` otherwise.
- R8: The privilege check uses the status word held when the request is accepted. A write that clears bit 13 makes the very next request, even one issued back to back, a user-mode request.
- R9: `done` pulses exactly one cycle after each accepted request. Without `req_valid`, no state changes. Class 0 is a no-op with cost 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| op_class | input | 3 | Operation class, 0 to 7 |
| op_low | input | 6 | Opcode bits 5:0 (mode field, direction bit, register field) |
| operand | input | 16 | Immediate or fetched operand word |
| ea_cost | input | 6 | Extra cycles of the addressing mode |
| areg_rdata | input | 32 | Value of the selected address register |
| areg_ridx | output | 3 | Index of the address register to read |
| sr | output | 16 | Current status word |
| supervisor | output | 1 | Status bit 13 |
| usp | output | 32 | Current user stack pointer |
| done | output | 1 | Result of the previous request is valid |
| priv_viol | output | 1 | Previous request violated privilege |
| cost | output | 8 | Cycle cost of the previous request |
| res_word | output | 16 | Status word returned by a status read |
| areg_we | output | 1 | Address-register write enable |
| areg_widx | output | 3 | Address register to write |
| areg_wdata | output | 32 | Data for the address-register write |

## Verification
Two functions meet when a status write clears the supervisor bit. The same write that leaves supervisor mode is still judged under the old privilege, and the next request is judged under the new one. The bench provokes this in two ways. It issues an AND with 0xDFFF and then a series of privileged requests, and it issues a full status write of zero followed at once by an OR with 0x2000. It expects the first write of each pair to be accepted with its normal cost, and the following privileged request to report a violation, cost 0 and an unchanged status word. Condition-code writes and status reads made after the drop to user mode are checked to still take effect.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_WR_SR  = 3'd1,
    OP_RD_SR  = 3'd2,
    OP_AND_SR = 3'd3,
    OP_OR_SR  = 3'd4,
    OP_XOR_SR = 3'd5,
    OP_WR_CCR = 3'd6,
    OP_USP    = 3'd7
  } op_cls_e;

  localparam int          SR_W      = 16;
  localparam int          SUPER_BIT = 13;
  localparam logic [15:0] SR_RESET  = 16'h2700;

  localparam int COST_RMW      = 20;
  localparam int COST_USP      = 4;
  localparam int COST_RD_REG   = 6;
  localparam int COST_RD_EA    = 8;
  localparam int COST_WR_BASE  = 12;

  // Operations that need the supervisor bit.
  function automatic logic needs_super(op_cls_e c);
    case (c)
      OP_WR_SR, OP_AND_SR, OP_OR_SR, OP_XOR_SR, OP_USP: needs_super = 1'b1;
      default:                                          needs_super = 1'b0;
    endcase
  endfunction

  // New status word for the operation (ignores privilege).
  function automatic logic [15:0] sr_apply(op_cls_e c, logic [15:0] cur,
                                           logic [15:0] opnd);
    case (c)
      OP_WR_SR:  sr_apply = opnd;
      OP_AND_SR: sr_apply = cur & opnd;
      OP_OR_SR:  sr_apply = cur | opnd;
      OP_XOR_SR: sr_apply = cur ^ opnd;
      OP_WR_CCR: sr_apply = {cur[15:8], opnd[7:0]};
      default:   sr_apply = cur;
    endcase
  endfunction

  function automatic logic writes_sr(op_cls_e c);
    case (c)
      OP_WR_SR, OP_AND_SR, OP_OR_SR, OP_XOR_SR, OP_WR_CCR: writes_sr = 1'b1;
      default:                                             writes_sr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/psw_next.sv
module psw_next
  import psw_pkg::*;
(
  input  op_cls_e     cls,
  input  logic [15:0] sr_cur,
  input  logic [15:0] operand,
  output logic [15:0] sr_nxt,
  output logic        sr_wen,
  output logic        viol
);

  logic in_super;
  assign in_super = sr_cur[SUPER_BIT];

  always_comb begin
    viol   = needs_super(cls) && !in_super;
    sr_wen = writes_sr(cls) && !viol;
    sr_nxt = sr_apply(cls, sr_cur, operand);
  end

  always_comb begin
    // R5
    if (cls == OP_WR_CCR) begin
      ccr_keeps_high_chk: assert (sr_nxt[15:8] == sr_cur[15:8] && !viol);
    end
    // R4
    if (cls == OP_USP && !in_super) begin
      usp_needs_super_chk: assert (viol && !sr_wen);
    end
  end

endmodule

// File: rtl/psw_cost.sv
module psw_cost
  import psw_pkg::*;
#(
  parameter int EAW = 6,
  parameter int CW  = 8
) (
  input  op_cls_e        cls,
  input  logic [2:0]     mode,
  input  logic [EAW-1:0] ea_cost,
  output logic [CW-1:0]  cost
);

  localparam logic [CW-1:0] C_RMW  = CW'(COST_RMW);
  localparam logic [CW-1:0] C_USP  = CW'(COST_USP);
  localparam logic [CW-1:0] C_RDR  = CW'(COST_RD_REG);
  localparam logic [CW-1:0] C_RDE  = CW'(COST_RD_EA);
  localparam logic [CW-1:0] C_WR   = CW'(COST_WR_BASE);

  logic [CW-1:0] ea_ext;
  assign ea_ext = CW'(ea_cost);

  always_comb begin
    case (cls)
      OP_WR_SR, OP_WR_CCR:           cost = C_WR + ea_ext;
      OP_RD_SR:                      cost = (mode == 3'd0) ? C_RDR : C_RDE + ea_ext;
      OP_AND_SR, OP_OR_SR, OP_XOR_SR: cost = C_RMW;
      OP_USP:                        cost = C_USP;
      default:                       cost = '0;
    endcase
  end

  always_comb begin
    // R3
    if (cls == OP_AND_SR || cls == OP_OR_SR || cls == OP_XOR_SR) begin
      rmw_cost_chk: assert (cost == C_RMW);
    end
    // R7
    if (cls == OP_RD_SR && mode == 3'd0) begin
      rd_reg_cost_chk: assert (cost == C_RDR);
    end
  end

endmodule

// File: rtl/psw_priv_unit.sv
module psw_priv_unit
  import psw_pkg::*;
#(
  parameter int EAW = 6,
  parameter int CW  = 8,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     op_class,
  input  logic [5:0]     op_low,
  input  logic [15:0]    operand,
  input  logic [EAW-1:0] ea_cost,
  input  logic [AW-1:0]  areg_rdata,
  output logic [2:0]     areg_ridx,
  output logic [15:0]    sr,
  output logic           supervisor,
  output logic [AW-1:0]  usp,
  output logic           done,
  output logic           priv_viol,
  output logic [CW-1:0]  cost,
  output logic [15:0]    res_word,
  output logic           areg_we,
  output logic [2:0]     areg_widx,
  output logic [AW-1:0]  areg_wdata
);

  op_cls_e        cls;
  logic           accept;
  logic [15:0]    sr_q, sr_nxt, res_q;
  logic           sr_wen, viol_now;
  logic [AW-1:0]  usp_q, wdata_q;
  logic [CW-1:0]  cost_now, cost_q;
  logic           done_q, viol_q, we_q;
  logic [2:0]     widx_q;
  logic           usp_load, usp_store, is_priv;

  assign cls       = op_cls_e'(op_class);
  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;
  assign is_priv   = needs_super(cls);
  assign usp_load  = accept && cls == OP_USP && !op_low[3] && !viol_now;
  assign usp_store = accept && cls == OP_USP &&  op_low[3] && !viol_now;

  psw_next u_next (
    .cls     (cls),
    .sr_cur  (sr_q),
    .operand (operand),
    .sr_nxt  (sr_nxt),
    .sr_wen  (sr_wen),
    .viol    (viol_now)
  );

  psw_cost #(.EAW(EAW), .CW(CW)) u_cost (
    .cls     (cls),
    .mode    (op_low[5:3]),
    .ea_cost (ea_cost),
    .cost    (cost_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= SR_RESET;
      usp_q   <= '0;
      done_q  <= 1'b0;
      viol_q  <= 1'b0;
      cost_q  <= '0;
      we_q    <= 1'b0;
      widx_q  <= '0;
      wdata_q <= '0;
      res_q   <= '0;
    end else begin
      done_q <= accept;
      viol_q <= accept && viol_now;
      cost_q <= (accept && !viol_now) ? cost_now : '0;
      we_q   <= usp_store;
      widx_q <= op_low[2:0];
      wdata_q <= usp_q;
      if (accept && sr_wen) sr_q <= sr_nxt;
      if (usp_load)         usp_q <= areg_rdata;
      if (accept && cls == OP_RD_SR) res_q <= sr_q;
    end
  end

  assign areg_ridx  = op_low[2:0];
  assign sr         = sr_q;
  assign supervisor = sr_q[SUPER_BIT];
  assign usp        = usp_q;
  assign done       = done_q;
  assign priv_viol  = viol_q;
  assign cost       = cost_q;
  assign res_word   = res_q;
  assign areg_we    = we_q;
  assign areg_widx  = widx_q;
  assign areg_wdata = wdata_q;

  // R4
  viol_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> (sr_q == $past(sr_q) && usp_q == $past(usp_q) && !areg_we && cost_q == '0));

  // R8
  user_priv_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && is_priv && !sr_q[SUPER_BIT]) |=> priv_viol);

  // R9
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_valid));

  // R9
  idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(sr_q) && $stable(usp_q) && !done));

  // R6
  store_not_viol_chk: assert property (@(posedge clk) disable iff (rst)
    areg_we |-> (done && !priv_viol && cost_q == CW'(COST_USP)));

endmodule

// File: tb/psw_priv_unit_test.sv
module psw_priv_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  op_class;
  logic [5:0]  op_low;
  logic [15:0] operand;
  logic [5:0]  ea_cost;
  logic [31:0] areg_rdata;
  logic [2:0]  areg_ridx;
  logic [15:0] sr;
  logic        supervisor;
  logic [31:0] usp;
  logic        done;
  logic        priv_viol;
  logic [7:0]  cost;
  logic [15:0] res_word;
  logic        areg_we;
  logic [2:0]  areg_widx;
  logic [31:0] areg_wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  psw_priv_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .op_class(op_class), .op_low(op_low), .operand(operand), .ea_cost(ea_cost),
    .areg_rdata(areg_rdata), .areg_ridx(areg_ridx), .sr(sr), .supervisor(supervisor),
    .usp(usp), .done(done), .priv_viol(priv_viol), .cost(cost), .res_word(res_word),
    .areg_we(areg_we), .areg_widx(areg_widx), .areg_wdata(areg_wdata)
  );

  // {class, op_low, operand, ea_cost, exp_sr, exp_viol, exp_cost}
  localparam int NV = 15;
  localparam logic [55:0] VEC [NV] = '{
    {3'd2, 6'o00, 16'h0000, 6'd5, 16'h2700, 1'b0, 8'd6 },  // R7 register read
    {3'd2, 6'o21, 16'h0000, 6'd4, 16'h2700, 1'b0, 8'd12},  // R7 memory read
    {3'd1, 6'o00, 16'h2715, 6'd3, 16'h2715, 1'b0, 8'd15},  // R2
    {3'd4, 6'o74, 16'h8000, 6'd0, 16'hA715, 1'b0, 8'd20},  // R3 OR
    {3'd5, 6'o74, 16'h00FF, 6'd0, 16'hA7EA, 1'b0, 8'd20},  // R3 XOR
    {3'd3, 6'o74, 16'hFF0F, 6'd0, 16'hA70A, 1'b0, 8'd20},  // R3 AND
    {3'd6, 6'o10, 16'h1234, 6'd2, 16'hA734, 1'b0, 8'd14},  // R5
    {3'd3, 6'o74, 16'hDFFF, 6'd0, 16'h8734, 1'b0, 8'd20},  // R8 drop to user
    {3'd4, 6'o74, 16'h2000, 6'd0, 16'h8734, 1'b1, 8'd0 },  // R4
    {3'd1, 6'o00, 16'h2700, 6'd0, 16'h8734, 1'b1, 8'd0 },  // R4
    {3'd6, 6'o00, 16'h00FF, 6'd0, 16'h87FF, 1'b0, 8'd12},  // R5 user mode
    {3'd2, 6'o00, 16'h0000, 6'd9, 16'h87FF, 1'b0, 8'd6 },  // R7 user mode
    {3'd7, 6'o00, 16'h0000, 6'd0, 16'h87FF, 1'b1, 8'd0 },  // R4 usp
    {3'd5, 6'o74, 16'hFFFF, 6'd0, 16'h87FF, 1'b1, 8'd0 },  // R4
    {3'd0, 6'o00, 16'hFFFF, 6'd7, 16'h87FF, 1'b0, 8'd0 }   // R9 no-op
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [5:0] lo,
                       input logic [15:0] op, input logic [5:0] ea, input logic [31:0] ar);
    op_class = c; op_low = lo; operand = op; ea_cost = ea; areg_rdata = ar;
    req_valid = 1'b1;
  endtask

  task automatic issue(input logic [2:0] c, input logic [5:0] lo,
                       input logic [15:0] op, input logic [5:0] ea, input logic [31:0] ar);
    @(negedge clk);
    drive(c, lo, op, ea, ar);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; op_class = '0; op_low = '0;
    operand = '0; ea_cost = '0; areg_rdata = '0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, req_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sr", {16'd0, sr}, 32'h2700);
    chk("R1 usp", usp, 32'd0);
    chk("R1 flags", {28'd0, done, priv_viol, areg_we, supervisor}, 32'h1);
    chk("R1 cost", {24'd0, cost}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      issue(v[55:53], v[52:47], v[46:31], v[30:25], 32'h1234_5600 + i);
      chk("R2/R3/R5/R8 sr", {16'd0, sr}, {16'd0, v[24:9]});
      chk("R4 viol", {31'd0, priv_viol}, {31'd0, v[8]});
      chk("R2/R3/R7 cost", {24'd0, cost}, {24'd0, v[7:0]});
      chk("R9 done", {31'd0, done}, 32'd1);
    end
    chk("R4 usp unchanged", usp, 32'd0);

    // R7 result word holds the status before a read
    do_reset();
    issue(3'd2, 6'o00, 16'h0, 6'd0, 32'h0);
    chk("R7 res_word", {16'd0, res_word}, 32'h2700);

    // R6 load then store of the user stack pointer
    issue(3'd7, 6'b000_011, 16'h0, 6'd0, 32'hDEAD_BEEF);
    chk("R6 usp load", usp, 32'hDEAD_BEEF);
    chk("R6 cost", {24'd0, cost}, 32'd4);
    chk("R6 no write", {31'd0, areg_we}, 32'd0);
    @(negedge clk);
    drive(3'd7, 6'b001_101, 16'h0, 6'd0, 32'h0);
    #1;
    chk("R6 ridx", {29'd0, areg_ridx}, 32'd5);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 store we", {31'd0, areg_we}, 32'd1);
    chk("R6 store idx", {29'd0, areg_widx}, 32'd5);
    chk("R6 store data", areg_wdata, 32'hDEAD_BEEF);

    // R9 no request: nothing changes
    @(negedge clk);
    op_class = 3'd1; operand = 16'h0000; req_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle sr", {16'd0, sr}, 32'h2700);
    chk("R9 idle done", {31'd0, done}, 32'd0);

    // R8 back-to-back: clear supervisor, then a privileged OR
    @(negedge clk);
    drive(3'd1, 6'o00, 16'h0000, 6'd1, 32'h0);
    @(negedge clk);
    chk("R8 write accepted", {24'd0, cost}, 32'd13);
    chk("R8 supervisor off", {31'd0, supervisor}, 32'd0);
    drive(3'd4, 6'o74, 16'h2000, 6'd0, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 next is user", {31'd0, priv_viol}, 32'd1);
    chk("R8 sr kept", {16'd0, sr}, 32'h0000);

    // R4 user-mode store attempt writes nothing
    issue(3'd7, 6'b001_010, 16'h0, 6'd0, 32'h5555_5555);
    chk("R4 no areg write", {31'd0, areg_we}, 32'd0);
    issue(3'd7, 6'b000_010, 16'h0, 6'd0, 32'h5555_5555);
    chk("R4 usp kept", usp, 32'hDEAD_BEEF);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule